// File: doc/BRIEF.md
# Late-Write Synchronous Static RAM

This block models a single-port synchronous static RAM for a bus that issues one command on every clock cycle, with no idle cycle between a read and a following write. Address, command and byte enables are taken at the rising edge. The write data for a write command arrives on a later cycle. That delay is one edge in flow-through mode and two edges in registered-output mode. Because of this delay, a write's data can reach the data pins while a later read's result is leaving the block.

A static mode pin chooses the output style. In registered mode, read data passes through an output register, and a write is completed two edges after its address. In flow-through mode, read data comes straight from the array, and a write is completed one edge after its address. Accesses can be extended into four-beat bursts in linear or interleaved order. Writes are masked per 9-bit byte. Three enables must all be high to select the block. An asynchronous output enable blanks the read port, and a sleep pin refuses new accesses. The array is a small internal register file.

Top module: `nbt_sram`

## Requirements
- R1: A new access is accepted only when `sel_a`, `sel_b` and `sel_c` are all 1 and `adv` is 0. Any other cycle that is not a burst continuation is a deselect. A deselect reads nothing and writes nothing, and it ends any running burst.
- R2: In registered mode (`pipe_mode`=1), a read accepted at edge n drives its word on `rdata`, with `rd_on`=1, from edge n+1 until edge n+2.
- R3: In flow-through mode (`pipe_mode`=0), a read accepted at edge n drives its word from edge n until edge n+1.
- R4: In registered mode, a write accepted at edge n stores the value that `wdata` has at edge n+2.
- R5: In flow-through mode, a write accepted at edge n stores the value that `wdata` has at edge n+1.
- R6: Enable bit `be[i]` governs data bits [9i+8:9i]. It is sampled at the same edge as the beat's address. Bytes whose enable is 0 keep their old contents.
- R7: Reads and writes may alternate on every cycle. A registered-mode read of a word whose write is due at the same edge returns the merged new data, not the old contents.
- R8: When a burst is running, `adv`=1 continues it. The address upper bits stay fixed. Beat k uses low bits (start+k) mod 4 when `burst_ilv`=0, and start XOR k when `burst_ilv`=1. The burst keeps its first beat's read/write direction. During a continuation the enables, `we` and `addr` are ignored. When no burst is running, `adv`=1 gives a deselect.
- R9: `oe`=0 forces `rd_on`=0 and `rdata`=0 at once, without waiting for a clock edge. It does not disturb reads that are in flight.
- R10: While `sleep`=1, each edge is a deselect and any burst ends. Writes already accepted still complete.
- R11: After reset, `rd_on`=0, `rdata`=0, no write is pending and every word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples all synchronous inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through; static |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear; static |
| sel_a | input | 1 | Select enable, active high |
| sel_b | input | 1 | Select enable, active high |
| sel_c | input | 1 | Select enable, active high |
| we | input | 1 | 1 = write, 0 = read, for a new access |
| adv | input | 1 | Continue the running burst |
| sleep | input | 1 | Refuse new accesses |
| oe | input | 1 | Asynchronous read output enable, active high |
| addr | input | AW | Word address of a new access |
| be | input | NB | Per-byte write enables |
| wdata | input | NB*BW | Late write data |
| rd_on | output | 1 | Read port is driving a valid word |
| rdata | output | NB*BW | Read data, 0 when not driving |

## Verification
The assertions assume that `pipe_mode` and `burst_ilv` change only while reset is held. They also assume that the address has at least three bits, so the burst block boundary exists. The stimulus changes these two pins only inside a reset pulse. It drives all other inputs on the falling edge, so the checker and the model sample settled values. The oe, sleep and select pins are varied freely between edges. A new burst can therefore start while writes from an earlier command are still waiting for their data.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_NEW,
        CMD_NEXT
    } cmd_kind_e;

    // Low two address bits of a burst beat
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/nbt_burst.sv
module nbt_burst import nbt_pkg::*; #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ilv,
    input  cmd_kind_e     kind,
    input  logic [AW-1:0] start_addr,
    input  logic          start_write,
    output logic          active_o,
    output logic          write_o,
    output logic [AW-1:0] next_addr_o
);
    typedef struct packed {
        logic          active;
        logic          write;
        logic [AW-1:0] base;
        logic [1:0]    beat;
    } bst_t;

    bst_t st_d, st_q;
    logic [1:0] beat_nx;

    always_comb begin
        st_d    = st_q;
        beat_nx = st_q.beat + 2'd1;
        case (kind)
            CMD_NEW: begin
                st_d.active = 1'b1;
                st_d.write  = start_write;
                st_d.base   = start_addr;
                st_d.beat   = 2'd0;
            end
            CMD_NEXT: st_d.beat = beat_nx;
            default:  st_d.active = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o    = st_q.active;
    assign write_o     = st_q.write;
    assign next_addr_o = {st_q.base[AW-1:2], beat_lo(st_q.base[1:0], beat_nx, ilv)};

endmodule

// File: rtl/nbt_mem.sv
module nbt_mem #(
    parameter int AW = 4,
    parameter int NB = 4,
    parameter int BW = 9,
    localparam int DW = NB * BW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [NB-1:0] wr_be,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int i = 0; i < NB; i++) begin
                if (wr_be[i]) mem_d[wr_addr][i*BW +: BW] = wr_data[i*BW +: BW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram import nbt_pkg::*; #(
    parameter int AW = 4,
    parameter int NB = 4,
    parameter int BW = 9,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          burst_ilv,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic          we,
    input  logic          adv,
    input  logic          sleep,
    input  logic          oe,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] be,
    input  logic [DW-1:0] wdata,
    output logic          rd_on,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          valid;
        logic          write;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } stage_t;

    typedef struct packed {
        stage_t        c1;   // accepted at the last edge
        stage_t        c2;   // accepted one edge before that
        logic          rv;   // registered read valid
        logic [DW-1:0] rd;   // registered read word
    } ctl_t;

    ctl_t          st_d, st_q;
    cmd_kind_e     kind;
    logic          b_active, b_write;
    logic [AW-1:0] b_next;
    stage_t        wr_stage;
    logic          mem_we;
    logic [DW-1:0] mem_rd, merged;
    logic          flow_v;

    // Signals observed by the bound checker
    logic          c1_valid, c1_write, rv_hold;
    logic [AW-1:0] c1_addr;

    nbt_burst #(.AW(AW)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .ilv         (burst_ilv),
        .kind        (kind),
        .start_addr  (addr),
        .start_write (we),
        .active_o    (b_active),
        .write_o     (b_write),
        .next_addr_o (b_next)
    );

    nbt_mem #(.AW(AW), .NB(NB), .BW(BW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_addr (wr_stage.addr),
        .wr_be   (wr_stage.be),
        .wr_data (wdata),
        .rd_addr (st_q.c1.addr),
        .rd_data (mem_rd)
    );

    always_comb begin
        // command decode
        if (sleep)                     kind = CMD_IDLE;
        else if (adv)                  kind = b_active ? CMD_NEXT : CMD_IDLE;
        else if (sel_a & sel_b & sel_c) kind = CMD_NEW;
        else                           kind = CMD_IDLE;

        st_d          = st_q;
        st_d.c1.valid = (kind != CMD_IDLE);
        st_d.c1.write = (kind == CMD_NEW) ? we : b_write;
        st_d.c1.addr  = (kind == CMD_NEW) ? addr : b_next;
        st_d.c1.be    = be;
        st_d.c2       = st_q.c1;

        // late write: data arrives one or two edges after its address
        wr_stage = pipe_mode ? st_q.c2 : st_q.c1;
        mem_we   = wr_stage.valid & wr_stage.write;

        // forward a write completing at this edge into the registered read
        merged = mem_rd;
        if (pipe_mode && st_q.c2.valid && st_q.c2.write && st_q.c2.addr == st_q.c1.addr) begin
            for (int i = 0; i < NB; i++) begin
                if (st_q.c2.be[i]) merged[i*BW +: BW] = wdata[i*BW +: BW];
            end
        end

        st_d.rv = pipe_mode & st_q.c1.valid & ~st_q.c1.write;
        st_d.rd = st_d.rv ? merged : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flow_v   = ~pipe_mode & st_q.c1.valid & ~st_q.c1.write;
    assign rd_on    = oe & (pipe_mode ? st_q.rv : flow_v);
    assign rdata    = rd_on ? (pipe_mode ? st_q.rd : mem_rd) : '0;

    assign c1_valid = st_q.c1.valid;
    assign c1_write = st_q.c1.write;
    assign c1_addr  = st_q.c1.addr;
    assign rv_hold  = st_q.rv;

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pipe_mode,
    input logic          sel_a,
    input logic          sel_b,
    input logic          sel_c,
    input logic          adv,
    input logic          sleep,
    input logic          oe,
    input logic          rd_on,
    input logic [DW-1:0] rdata,
    input logic          c1_valid,
    input logic          c1_write,
    input logic [AW-1:0] c1_addr,
    input logic          rv_hold
);
    a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !adv && !(sel_a && sel_b && sel_c)) |=> !c1_valid);

    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !c1_valid);

    a_r8_burst_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && adv && c1_valid) |=>
            (c1_valid && c1_addr[AW-1:2] == $past(c1_addr[AW-1:2]) && c1_write == $past(c1_write)));

    a_r2_pipe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && c1_valid && !c1_write) |=> rv_hold);

    a_r3_flow_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && oe && c1_valid && !c1_write) |-> rd_on);

    a_r9_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!rd_on && rdata == '0));

endmodule

bind nbt_sram nbt_sram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .sel_c     (sel_c),
    .adv       (adv),
    .sleep     (sleep),
    .oe        (oe),
    .rd_on     (rd_on),
    .rdata     (rdata),
    .c1_valid  (c1_valid),
    .c1_write  (c1_write),
    .c1_addr   (c1_addr),
    .rv_hold   (rv_hold)
);

// File: tb/sim_nbt_sram.sv
module sim_nbt_sram;
    localparam int AW = 4;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1, burst_ilv = 1'b0;
    logic          sel_a = 0, sel_b = 0, sel_c = 0, we = 0, adv = 0, sleep = 0, oe = 1;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] be = '0;
    logic [DW-1:0] wdata = '0;
    logic          rd_on;
    logic [DW-1:0] rdata;

    always #5 clk = ~clk;

    nbt_sram #(.AW(AW), .NB(NB), .BW(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .we(we), .adv(adv),
        .sleep(sleep), .oe(oe), .addr(addr), .be(be), .wdata(wdata),
        .rd_on(rd_on), .rdata(rdata)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct {
        int            a;
        logic [NB-1:0] b;
        int            due;
    } pend_t;

    logic [DW-1:0] m [DEPTH];
    pend_t         pq[$];
    int            edge_n;
    bit            b_act, b_wr;
    int            b_base, b_beat;
    bit            pr_v;
    int            pr_a;
    bit            exp_v;
    logic [DW-1:0] exp_d;

    int    checks = 0, failures = 0;
    string cur_req = "R11";
    bit    done = 0;

    task automatic model_clear();
        for (int k = 0; k < DEPTH; k++) m[k] = '0;
        pq.delete();
        edge_n = 0; b_act = 0; b_wr = 0; b_base = 0; b_beat = 0;
        pr_v = 0; pr_a = 0; exp_v = 0; exp_d = '0;
    endtask

    task automatic model_step();
        int  ea;
        bit  acc;
        edge_n++;
        for (int i = pq.size() - 1; i >= 0; i--) begin
            if (pq[i].due == edge_n) begin
                for (int j = 0; j < NB; j++)
                    if (pq[i].b[j]) m[pq[i].a][j*BW +: BW] = wdata[j*BW +: BW];
                pq.delete(i);
            end
        end
        if (pipe_mode) begin
            exp_v = pr_v;
            exp_d = pr_v ? m[pr_a] : '0;
            pr_v  = 0;
        end else begin
            exp_v = 0;
        end
        acc = 0; ea = 0;
        if (sleep) begin
            b_act = 0;
        end else if (adv) begin
            if (b_act) begin
                b_beat = (b_beat + 1) % 4;
                if (burst_ilv) ea = (b_base & ~3) | ((b_base & 3) ^ b_beat);
                else           ea = (b_base & ~3) | (((b_base & 3) + b_beat) % 4);
                acc = 1;
            end
        end else if (sel_a && sel_b && sel_c) begin
            b_act = 1; b_base = int'(addr); b_beat = 0; b_wr = we;
            ea = int'(addr); acc = 1;
        end else begin
            b_act = 0;
        end
        if (acc) begin
            if (b_wr) begin
                pend_t p;
                p.a = ea; p.b = be; p.due = edge_n + (pipe_mode ? 2 : 1);
                pq.push_back(p);
            end else if (pipe_mode) begin
                pr_v = 1; pr_a = ea;
            end else begin
                exp_v = 1; exp_d = m[ea];
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_clear();
        else        model_step();
    end

    // ---------------- stimulus and comparison ----------------
    task automatic compare();
        logic          e_on;
        logic [DW-1:0] e_rd;
        e_on = oe && exp_v;
        e_rd = e_on ? exp_d : '0;
        checks++;
        if (rd_on !== e_on || rdata !== e_rd) begin
            failures++;
            $display("FAIL %s t=%0t rd_on=%b exp=%b rdata=%h exp=%h",
                     cur_req, $time, rd_on, e_on, rdata, e_rd);
        end
    endtask

    task automatic cyc(input logic [2:0] s, input logic w, input int a, input logic ad,
                       input logic [NB-1:0] b, input logic o, input logic sl);
        @(negedge clk);
        {sel_a, sel_b, sel_c} = s;
        we = w; addr = AW'(a); adv = ad; be = b; oe = o; sleep = sl;
        wdata = {$urandom, $urandom};
        #1 compare();
    endtask

    task automatic wr(input int a, input logic [NB-1:0] b); cyc(3'b111, 1, a, 0, b, 1, 0); endtask
    task automatic rd(input int a); cyc(3'b111, 0, a, 0, '0, 1, 0); endtask
    task automatic nop(input int n); for (int i = 0; i < n; i++) cyc(3'b000, 0, 0, 0, '0, 1, 0); endtask
    task automatic nx(input logic w); cyc(3'b010, w, 0, 1, 4'hF, 1, 0); endtask  // enables ignored on advance

    task automatic do_reset(input logic pm, input logic il);
        @(negedge clk);
        rst_n = 0; pipe_mode = pm; burst_ilv = il;
        {sel_a, sel_b, sel_c} = 3'b000; adv = 0; sleep = 0; oe = 1;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [2:0] s;
            s = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b111;
            cyc(s, 1'($urandom), $urandom_range(0, DEPTH - 1), ($urandom_range(0, 3) == 0),
                4'($urandom), ($urandom_range(0, 7) != 0), ($urandom_range(0, 15) == 0));
        end
    endtask

    task automatic mode_suite();
        cur_req = "R11"; nop(2); rd(5); rd(9); nop(2);
        cur_req = pipe_mode ? "R4" : "R5";
        wr(3, 4'hF); nop(2); rd(3); nop(2);
        wr(4, 4'hF); wr(5, 4'hF); rd(4); rd(5); nop(2);
        cur_req = "R6";
        wr(3, 4'b0101); nop(2); rd(3); wr(3, 4'b1000); nop(2); rd(3); nop(2);
        cur_req = "R7";
        for (int i = 0; i < 6; i++) begin wr(7, 4'($urandom)); rd(7); end
        wr(8, 4'hF); rd(8); rd(8); wr(8, 4'b0011); rd(8); nop(3);
        cur_req = "R1";
        wr(2, 4'hF); nop(2);
        cyc(3'b110, 1, 2, 0, 4'hF, 1, 0); cyc(3'b101, 1, 2, 0, 4'hF, 1, 0);
        cyc(3'b011, 0, 2, 0, 4'hF, 1, 0); nop(2); rd(2); nop(2);
        cur_req = "R8";
        wr(6, 4'hF); nx(0); nx(0); nx(0); nop(3);
        rd(5); nx(1); nx(1); nx(1); nx(1); nop(2);
        rd(14); nx(0); nop(1); nx(0); nx(0); nop(2);   // advance with no burst: deselect
        cur_req = pipe_mode ? "R2" : "R3";
        for (int i = 0; i < 8; i++) rd(i); nop(2);
        cur_req = "R9";
        rd(6); cyc(3'b111, 0, 7, 0, '0, 0, 0); cyc(3'b000, 0, 0, 0, '0, 0, 0);
        cyc(3'b000, 0, 0, 0, '0, 1, 0); rd(5);
        @(negedge clk); oe = 0; #1 compare(); #2 oe = 1; #1 compare();
        nop(2);
        cur_req = "R10";
        wr(9, 4'hF); cyc(3'b111, 1, 10, 0, 4'hF, 1, 1); cyc(3'b111, 0, 9, 0, '0, 1, 1);
        nop(2); rd(9); rd(10);
        rd(12); nx(0); cyc(3'b111, 0, 0, 1, '0, 1, 1); nx(0); nop(2);
        cur_req = pipe_mode ? "R2" : "R3";
        random_run(300);
        nop(3);
    endtask

    initial begin
        model_clear();
        do_reset(1'b1, 1'b0);
        mode_suite();
        do_reset(1'b0, 1'b1);
        mode_suite();
        do_reset(1'b1, 1'b1);
        cur_req = "R8";
        wr(13, 4'hF); nx(1); nx(1); nx(1); rd(13); nx(0); nx(0); nx(0); nop(3);
        random_run(200);
        do_reset(1'b0, 1'b0);
        cur_req = "R8";
        rd(11); nx(0); nx(0); nx(0); nop(2);
        random_run(200);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule